// File: doc/BRIEF.md
# Receive Packet Skip Controller

This block runs the read side of a circular receive buffer that holds whole packets back to back. Each packet begins with a header location that holds its total length in locations, header included. The host pulls packet data one location per transfer through a valid/ready stream. The controller drives the buffer address and passes the addressed word straight through as stream data.

The host can also drop the unread tail of the current packet. It writes a control word with the skip bit set. The controller then reports busy for a fixed number of clocks, moves the read pointer to the next packet boundary and lowers busy. A skip request that comes too early in a packet, or too close to its end, does not move anything and sets a sticky error flag instead. The write side of the buffer is outside the block. It only signals, with a one-cycle pulse, that one more complete packet has been stored.

Stream rules: `rx_valid` is high while at least one packet is stored and no skip is running. A word moves on every cycle where `rx_valid` and `rx_ready` are both high. While the host holds `rx_ready` low, the address and the presented word stay put. A `rx_ready` with no `rx_valid` moves nothing.

Top module: `rskip_ctrl`

## Requirements
- R1: After reset, `rx_valid`, `avail_cnt`, `buf_addr` and both status bits are 0.
- R2: Each accepted transfer presents the buffer word at `buf_addr` and then advances `buf_addr` by one, modulo DEPTH. While `rx_valid` is high and `rx_ready` is low, `buf_addr` holds.
- R3: The first location of a packet holds its total length L (1 to 2^DATA_W-1, header included). Transferring its L-th location decrements `avail_cnt` and starts the next packet at the following address.
- R4: A write with `cfg_wdata` bit 2 set is accepted when at least MIN_READS locations of the current packet have been read and more than MIN_LEFT remain. `cfg_rdata` bit 2 then reads 1 for exactly SKIP_CYCLES cycles and 0 after that.
- R5: When an accepted skip completes, `buf_addr` becomes (packet start + L) modulo DEPTH, `avail_cnt` drops by one, and the per-packet read count restarts at zero.
- R6: If no packet remains after a skip or a read, `rx_valid` stays low.
- R7: A skip request made with fewer than MIN_READS locations read (including when no packet is stored) leaves `buf_addr` and `avail_cnt` unchanged, leaves bit 2 low, and sets `cfg_rdata` bit 0.
- R8: A skip request made with MIN_LEFT or fewer locations of the packet left leaves `buf_addr` unchanged and sets `cfg_rdata` bit 0.
- R9: `cfg_rdata` bit 0 stays set until a write with `cfg_wdata` bit 0 set clears it. A new rejection in the same write wins over the clear.
- R10: While a skip runs, `rx_valid` is low, and host `rx_ready` strobes do not move `buf_addr`.
- R11: A `pkt_push` pulse raises `avail_cnt` by one. A push in the same cycle as a packet completion leaves `avail_cnt` unchanged.
- R12: A skip request written while a skip is already running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word: bit 2 skip, bit 0 clear error |
| cfg_rdata | output | 8 | Status: bit 2 skip busy, bit 0 sticky error |
| pkt_push | input | 1 | One more complete packet stored |
| avail_cnt | output | $clog2(DEPTH+1) | Packets stored and not yet consumed |
| buf_addr | output | $clog2(DEPTH) | Buffer read address |
| buf_rdata | input | DATA_W | Buffer word at buf_addr (same-cycle read) |
| rx_valid | output | 1 | Stream word available |
| rx_ready | input | 1 | Host read strobe |
| rx_data | output | DATA_W | Stream word |

## Verification
The bench builds the block with DEPTH 64, DATA_W 8 and SKIP_CYCLES 5. A buffer this small makes random packets of up to 40 locations wrap the pointer many times, both on reads and on skip jumps. A skip of 5 cycles leaves room to check the busy window and to issue strobes and repeat skip requests inside it. MIN_READS and MIN_LEFT keep their default values of 4 and 8. Directed packets of 13 and 20 locations therefore place requests at exactly three and four reads, and at exactly eight and nine locations left.

// File: rtl/rskip_pkg.sv
package rskip_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned ERR_BIT  = 0;
  localparam int unsigned SKIP_BIT = 2;
endpackage

// File: rtl/rskip_timer.sv
module rskip_timer #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned TW = $clog2(CYCLES + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (start && cnt_q == '0) cnt_q <= TW'(CYCLES);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == TW'(1));

  p_count_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(CYCLES));
  p_done_ends_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_start_sets_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: rtl/rskip_guard.sv
module rskip_guard #(
  parameter int unsigned LW        = 8,
  parameter int unsigned MIN_READS = 4,
  parameter int unsigned MIN_LEFT  = 8
) (
  input  logic          have_pkt,
  input  logic [LW-1:0] rd_cnt,
  input  logic [LW-1:0] pkt_len,
  output logic          ok
);
  logic [LW-1:0] left;

  always_comb begin
    left = pkt_len - rd_cnt;
    ok   = have_pkt && (rd_cnt >= LW'(MIN_READS)) && (left > LW'(MIN_LEFT));
  end
endmodule

// File: rtl/rskip_cursor.sv
module rskip_cursor #(
  parameter int unsigned AW = 8,
  parameter int unsigned LW = 8,
  parameter int unsigned VW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer,
  input  logic [LW-1:0] hdr,
  input  logic          skip_done,
  input  logic          push,
  output logic [AW-1:0] ptr,
  output logic [LW-1:0] rd_cnt,
  output logic [LW-1:0] len,
  output logic [VW-1:0] avail
);
  localparam int unsigned SW = (AW > LW) ? AW : LW;

  logic [AW-1:0] ptr_q, start_q, jump;
  logic [LW-1:0] cnt_q, len_q, eff_len;
  logic [VW-1:0] avail_q;
  logic [SW-1:0] jump_w;
  logic          last, pop;

  always_comb begin
    eff_len = (cnt_q == '0) ? hdr : len_q;
    last    = xfer && ((cnt_q + 1'b1) == eff_len);
    pop     = skip_done || last;
    jump_w  = SW'(start_q) + SW'(len_q);
    jump    = jump_w[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
    end else if (skip_done) begin
      ptr_q   <= jump;
      start_q <= jump;
      cnt_q   <= '0;
    end else if (xfer) begin
      ptr_q <= ptr_q + 1'b1;
      if (cnt_q == '0) len_q <= hdr;
      if (last) begin
        cnt_q   <= '0;
        start_q <= ptr_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) avail_q <= '0;
    else if (push && !pop) avail_q <= avail_q + 1'b1;
    else if (!push && pop) avail_q <= avail_q - 1'b1;
  end

  assign ptr    = ptr_q;
  assign rd_cnt = cnt_q;
  assign len    = len_q;
  assign avail  = avail_q;

  p_skip_restarts_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    skip_done |=> (cnt_q == '0));
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |-> (avail_q != '0));
endmodule

// File: rtl/rskip_ctrl.sv
module rskip_ctrl
  import rskip_pkg::*;
#(
  parameter int unsigned DEPTH       = 256,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SKIP_CYCLES = 4,
  parameter int unsigned MIN_READS   = 4,
  parameter int unsigned MIN_LEFT    = 8,
  localparam int unsigned AW         = $clog2(DEPTH),
  localparam int unsigned VW         = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              pkt_push,
  output logic [VW-1:0]     avail_cnt,
  output logic [AW-1:0]     buf_addr,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data
);
  logic              busy, done, ok, err_q;
  logic              skip_req, accept, reject, xfer;
  logic [DATA_W-1:0] rd_cnt, pkt_len;
  logic              unused_wbits;

  assign unused_wbits = ^cfg_wdata;

  assign skip_req = cfg_wr && cfg_wdata[SKIP_BIT] && !busy;
  assign accept   = skip_req && ok;
  assign reject   = skip_req && !ok;
  assign rx_valid = (avail_cnt != '0) && !busy;
  assign xfer     = rx_valid && rx_ready;
  assign rx_data  = buf_rdata;

  rskip_guard #(.LW(DATA_W), .MIN_READS(MIN_READS), .MIN_LEFT(MIN_LEFT)) u_guard (
    .have_pkt(avail_cnt != '0), .rd_cnt(rd_cnt), .pkt_len(pkt_len), .ok(ok));

  rskip_timer #(.CYCLES(SKIP_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy), .done(done));

  rskip_cursor #(.AW(AW), .LW(DATA_W), .VW(VW)) u_cursor (
    .clk(clk), .rst_n(rst_n), .xfer(xfer), .hdr(buf_rdata), .skip_done(done),
    .push(pkt_push), .ptr(buf_addr), .rd_cnt(rd_cnt), .len(pkt_len), .avail(avail_cnt));

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else if (reject) err_q <= 1'b1;
    else if (cfg_wr && cfg_wdata[ERR_BIT]) err_q <= 1'b0;
  end

  always_comb begin
    cfg_rdata           = '0;
    cfg_rdata[SKIP_BIT] = busy;
    cfg_rdata[ERR_BIT]  = err_q;
  end

  p_busy_blocks_stream_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rx_valid);
  p_reject_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> cfg_rdata[ERR_BIT]);
  p_reject_keeps_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !xfer) |=> $stable(buf_addr));
  p_hold_under_backpressure_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready && !accept) |=> (rx_valid && $stable(buf_addr)));
endmodule

// File: tb/tb_rskip_ctrl.sv
module tb_rskip_ctrl;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 64;
  localparam int DW     = 8;
  localparam int SKIPC  = 5;
  localparam int AW     = $clog2(DEPTH);
  localparam int VW     = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic rst_n, cfg_wr, pkt_push, rx_valid, rx_ready;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic [VW-1:0] avail_cnt;
  logic [AW-1:0] buf_addr;
  logic [DW-1:0] buf_rdata, rx_data;
  logic [DW-1:0] mem [DEPTH];

  assign buf_rdata = mem[buf_addr];

  rskip_ctrl #(.DEPTH(DEPTH), .DATA_W(DW), .SKIP_CYCLES(SKIPC)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pkt_push(pkt_push), .avail_cnt(avail_cnt), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data));

  int checks = 0, errors = 0;
  int exp_ptr = 0, exp_start = 0, exp_len = 0, exp_cnt = 0, exp_avail = 0, exp_err = 0;
  int wp = 0, occupied = 0;
  bit done_flag = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit skip_ok();
    return (exp_avail > 0) && (exp_cnt >= 4) && (exp_len - exp_cnt > 8);
  endfunction

  task automatic check_state(input string tag);
    chk({tag, " addr"}, int'(buf_addr), exp_ptr);
    chk({tag, " avail"}, int'(avail_cnt), exp_avail);
    chk({tag, " valid"}, int'(rx_valid), int'(exp_avail > 0));
    chk({tag, " err"}, int'(cfg_rdata[0]), exp_err);
  endtask

  // One cycle: optional host read, optional packet push (push_len 0 = none).
  task automatic step(input bit rd, input int push_len);
    bit moved;
    rx_ready = rd;
    if (push_len > 0) begin
      for (int i = 0; i < push_len; i++)
        mem[(wp + i) % DEPTH] = (i == 0) ? DW'(push_len) : DW'($urandom);
      wp = (wp + push_len) % DEPTH;
      occupied += push_len;
      pkt_push = 1'b1;
    end
    moved = rd && (exp_avail > 0);
    if (moved) chk("R2 data", int'(rx_data), int'(mem[exp_ptr]));
    if (rd && exp_avail == 0) chk("R6 no valid", int'(rx_valid), 0);
    @(posedge clk); #1;
    @(negedge clk);
    rx_ready = 1'b0;
    pkt_push = 1'b0;
    if (push_len > 0) exp_avail++;
    if (moved) begin
      if (exp_cnt == 0) exp_len = int'(mem[exp_ptr]);
      exp_cnt++;
      exp_ptr = (exp_ptr + 1) % DEPTH;
      if (exp_cnt == exp_len) begin
        exp_avail--;
        occupied -= exp_len;
        exp_cnt = 0;
        exp_start = exp_ptr;
      end
    end
    check_state("R2/R3/R11");
  endtask

  task automatic backpressure();
    int a;
    a = int'(buf_addr);
    rx_ready = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R2 hold addr", int'(buf_addr), a);
    chk("R2 hold valid", int'(rx_valid), int'(exp_avail > 0));
  endtask

  task automatic skip_cmd(input bit with_clear);
    bit ok;
    ok = skip_ok();
    cfg_wr = 1'b1;
    cfg_wdata = with_clear ? 8'h05 : 8'h04;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0;
    cfg_wdata = 8'h00;
    if (ok) begin
      for (int k = 0; k < SKIPC; k++) begin
        chk("R4 busy", int'(cfg_rdata[2]), 1);
        chk("R10 addr frozen", int'(buf_addr), exp_ptr);
        chk("R10 valid low", int'(rx_valid), 0);
        rx_ready = 1'b1;
        if (k == 1) begin cfg_wr = 1'b1; cfg_wdata = 8'h04; end
        @(posedge clk); @(negedge clk);
        cfg_wr = 1'b0;
        cfg_wdata = 8'h00;
        rx_ready = 1'b0;
      end
      chk("R4 busy cleared", int'(cfg_rdata[2]), 0);
      chk("R12 no error from repeat", int'(cfg_rdata[0]), exp_err);
      exp_ptr = (exp_start + exp_len) % DEPTH;
      exp_start = exp_ptr;
      exp_avail--;
      occupied -= exp_len;
      exp_cnt = 0;
      check_state("R5/R6 after skip");
    end else begin
      exp_err = 1;
      chk("R7/R8 not busy", int'(cfg_rdata[2]), 0);
      check_state("R7/R8 rejected");
    end
  endtask

  task automatic clear_err();
    cfg_wr = 1'b1;
    cfg_wdata = 8'h01;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0;
    cfg_wdata = 8'h00;
    exp_err = 0;
    chk("R9 cleared", int'(cfg_rdata[0]), 0);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; pkt_push = 1'b0; rx_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 valid", int'(rx_valid), 0);
    chk("R1 avail", int'(avail_cnt), 0);
    chk("R1 addr", int'(buf_addr), 0);
    chk("R1 status", int'(cfg_rdata), 0);

    // R7 with nothing stored
    skip_cmd(1'b0);
    chk("R9 sticky", int'(cfg_rdata[0]), 1);
    clear_err();

    step(1'b0, 13);
    step(1'b0, 20);
    repeat (3) step(1'b1, 0);
    skip_cmd(1'b0);                 // R7: three reads only
    backpressure();
    chk("R9 still set", int'(cfg_rdata[0]), 1);
    clear_err();
    step(1'b1, 0);
    skip_cmd(1'b0);                 // R4/R5: four reads, nine left
    repeat (12) step(1'b1, 0);
    skip_cmd(1'b1);                 // R8: eight left; R9 reject wins over clear
    chk("R9 set wins", int'(cfg_rdata[0]), 1);
    clear_err();
    repeat (8) step(1'b1, 0);       // R3: finish by reads
    chk("R6 empty", int'(rx_valid), 0);
    step(1'b0, 16);
    repeat (4) step(1'b1, 0);
    skip_cmd(1'b0);                 // R6: skip leaves nothing
    step(1'b0, 5);
    repeat (4) step(1'b1, 0);
    step(1'b1, 6);                  // R11: push with completion
    repeat (6) step(1'b1, 0);

    for (int it = 0; it < 4000; it++) begin
      int op, len;
      op = int'($urandom % 10);
      len = 1 + int'($urandom % 40);
      if (op < 2 || exp_avail == 0) begin
        if (occupied + len <= DEPTH) step(1'b0, len);
        else step(1'b1, 0);
      end else if (op < 6) step(1'b1, 0);
      else if (op == 6) begin
        if (occupied + len <= DEPTH) step(1'b1, len);
        else step(1'b1, 0);
      end else if (op == 7) begin
        if (skip_ok() || ($urandom % 4 == 0)) skip_cmd(1'b0);
        else step(1'b1, 0);
      end else if (op == 8) backpressure();
      else if (exp_err != 0) clear_err();
      else step(1'b0, 0);
    end

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule